// File: doc/BRIEF.md
# Byte-Lane Steering External Bus Bridge

This block connects an internal request port to a 16-bit asynchronous external bus. A requester presents an address, a byte or word size, a direction, an I/O-space flag and write data, and holds `req` until `ack` returns. The bridge places the bytes on the correct data lane and drives the address and the strobes. It splits a word access at an odd address into two bus cycles. It asserts one of seven peripheral selects for I/O accesses in the low 3.5 KB of I/O space. Each strobe is held for a programmed number of wait states and then for as long as the external device keeps `ardy` low.

A static strap input `mode_sel` picks one of two byte-enable conventions. In mode 0 the full byte address is driven, and `bhe_n` together with address bit 0 marks the active lanes; writes use the single strobe `wr_n`. In mode 1 the address is a word address with bit 0 held at 0, and writes use separate lane strobes `wrl_n` and `wrh_n`. Reads use `rd_n` in both modes.

Top module: `extbus_bridge`

## Requirements
- R1: In mode 0, `bus_addr` carries the full cycle address. `bhe_n` is low exactly when the upper lane (D15:8) is used: it is high for a byte at an even address, low for a byte at an odd address, and low for an aligned word.
- R2: In mode 1, `bus_addr[0]` is 0 during every bus cycle. `wr_n` and `bhe_n` stay high. A write drives `wrl_n` low for the lower lane and `wrh_n` low for the upper lane, so an aligned word write pulls both low.
- R3: A byte write drives the byte on both lanes: write data 0x23 appears as 0x2323 on `bus_dout`, and `bus_oe` is high while the strobe is active.
- R4: In mode 1, a byte write to an odd address drives the even word address and pulls only `wrh_n` low.
- R5: A word access at an odd address A runs as two bus cycles in both modes. The first cycle is at A and uses the upper lane only. The second is at A+1 and uses the lower lane only. One cycle with all strobes high separates them. Write data is byte-swapped on the bus in both cycles, so 0x5678 appears as 0x7856.
- R6: Read data returns zero-extended in `rdata`. A byte at an even address comes from D7:0 and a byte at an odd address from D15:8. A split word read returns the first cycle's upper-lane byte in `rdata[7:0]` and the second cycle's lower-lane byte in `rdata[15:8]`.
- R7: During an I/O access whose address is below 0xE00, `pcs_n[k]` is low for the whole strobe, where k = address bits 11:9; each select covers a 512-byte window. No select is asserted for memory accesses or for I/O addresses at or above 0xE00, and no select is low outside a strobe.
- R8: With `ardy` held high, each bus cycle's strobe stays active for `wait_cfg`+1 clocks. If `ardy` is low for the first L clocks of a cycle, the strobe lasts max(`wait_cfg`, L)+1 clocks.
- R9: `ack` is a single-cycle pulse in the clock after the last bus cycle ends, and `rdata` is valid while it is high. `ack` is low after reset and all strobes and selects are inactive.
- R10: In mode 0, a write uses `wr_n`, and `wrl_n`/`wrh_n` stay high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 1 | Byte-enable convention strap (0: bhe_n+A0, 1: lane write strobes) |
| wait_cfg | input | 4 | Wait states inserted before `ardy` is sampled |
| req | input | 1 | Request valid, held until `ack` |
| req_we | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_io | input | 1 | 1 = I/O space (peripheral selects decoded) |
| req_addr | input | 23 | Byte address |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| ack | output | 1 | Completion pulse |
| rdata | output | 16 | Read result, valid with `ack` |
| bus_addr | output | 23 | External address |
| bus_dout | output | 16 | External write data |
| bus_oe | output | 1 | Write data drive enable |
| bus_din | input | 16 | External read data |
| rd_n | output | 1 | Read strobe |
| wr_n | output | 1 | Write strobe (mode 0) |
| wrl_n | output | 1 | Lower-lane write strobe (mode 1) |
| wrh_n | output | 1 | Upper-lane write strobe (mode 1) |
| bhe_n | output | 1 | Upper-lane enable (mode 0) |
| pcs_n | output | 7 | Peripheral selects, active low |
| ardy | input | 1 | External ready |

## Verification
Byte writes to even and odd addresses in both modes show that the bridge duplicates the byte and picks the right lane enable or lane strobe. An odd-address byte write in mode 1 separates word addressing from byte addressing. Aligned and odd-address word writes and reads use distinct values on each data lane, so a missed split, an unswapped byte or a reversed reassembly each give a visibly wrong result. I/O addresses inside several windows, on the first address past the last window, and in memory space exercise the select decode. Runs with different wait counts, with and without a long `ardy` hold, measure the strobe length.

// File: rtl/extbus_pkg.sv
// Shared types for the external bus bridge.
package extbus_pkg;
    // Sequencer states: idle, strobe active, inter-cycle gap, completion.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_BUS  = 2'd1,
        ST_GAP  = 2'd2,
        ST_DONE = 2'd3
    } seq_state_t;
endpackage

// File: rtl/extbus_lane_steer.sv
// Lane steering: works out the address of the current bus cycle, which
// data lanes it uses, the pin-level address for the strap mode, and the
// write data placed on the bus.
// Assumes: base_addr/word/wdata are stable latched request fields and
// phase selects the second half of a split odd-address word.
module extbus_lane_steer #(
    parameter int AW = 23,
    parameter int DW = 16
) (
    input  logic          mode_sel,
    input  logic [AW-1:0] base_addr,
    input  logic          word,
    input  logic          phase,
    input  logic [DW-1:0] wdata,
    output logic [AW-1:0] cyc_addr,
    output logic [AW-1:0] pin_addr,
    output logic          lo_en,
    output logic          hi_en,
    output logic [DW-1:0] dout
);
    localparam int BW = DW / 2;

    logic split;
    logic both;

    // Cycle address and lane usage.
    always_comb begin
        split    = word & base_addr[0];
        both     = word & ~split;
        cyc_addr = phase ? base_addr + {{(AW-1){1'b0}}, 1'b1} : base_addr;
        hi_en    = both | cyc_addr[0];
        lo_en    = both | ~cyc_addr[0];
    end

    // Pin address: byte address in mode 0, word address in mode 1.
    always_comb begin
        if (mode_sel) pin_addr = {cyc_addr[AW-1:1], 1'b0};
        else          pin_addr = cyc_addr;
    end

    // Write data: duplicated byte, swapped split word, or plain word.
    always_comb begin
        if (!word)      dout = {wdata[BW-1:0], wdata[BW-1:0]};
        else if (split) dout = {wdata[BW-1:0], wdata[DW-1:BW]};
        else            dout = wdata;
    end
endmodule

// File: rtl/extbus_pcs_decode.sv
// Peripheral select decode: one active-low select per fixed-size I/O
// window, starting at address 0, asserted only while en is high.
// Assumes: windows are a power of two in size and contiguous.
module extbus_pcs_decode #(
    parameter int AW       = 23,
    parameter int PCS_N    = 7,
    parameter int WIN_BITS = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [AW-1:0]    addr,
    output logic [PCS_N-1:0] pcs_n
);
    localparam int SEL_W = (PCS_N > 1) ? $clog2(PCS_N) : 1;
    localparam int TOP   = WIN_BITS + SEL_W;

    logic             hi_zero;
    logic [SEL_W-1:0] idx;

    // Window index and upper-address range check.
    always_comb begin
        hi_zero = (addr[AW-1:TOP] == '0);
        idx     = addr[WIN_BITS +: SEL_W];
    end

    // One select per window.
    for (genvar i = 0; i < PCS_N; i++) begin : g_sel
        assign pcs_n[i] = ~(en & hi_zero & (idx == SEL_W'(i)));
    end

    // R7: at most one select active at any time.
    p_pcs_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~pcs_n));
endmodule

// File: rtl/extbus_seq.sv
// Bus cycle sequencer: accepts a request, runs one or two strobe cycles
// each stretched by the wait count and ardy, assembles read data and
// pulses ack when the access is complete.
// Assumes: req and its fields are held until ack; hi_en comes from the
// lane steering for the current cycle.
module extbus_seq
    import extbus_pkg::*;
#(
    parameter int AW   = 23,
    parameter int DW   = 16,
    parameter int WS_W = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req,
    input  logic            req_we,
    input  logic            req_word,
    input  logic            req_io,
    input  logic [AW-1:0]   req_addr,
    input  logic [DW-1:0]   req_wdata,
    input  logic [WS_W-1:0] wait_cfg,
    input  logic            ardy,
    input  logic [DW-1:0]   bus_din,
    input  logic            hi_en,
    output seq_state_t      state,
    output logic            phase,
    output logic [AW-1:0]   lat_addr,
    output logic            lat_we,
    output logic            lat_word,
    output logic            lat_io,
    output logic [DW-1:0]   lat_wdata,
    output logic            ack,
    output logic [DW-1:0]   rdata
);
    localparam int BW = DW / 2;

    logic [WS_W-1:0] cnt;
    logic            split;
    logic [BW-1:0]   byte_in;

    // Split flag and lane-selected read byte.
    always_comb begin
        split   = lat_word & lat_addr[0];
        byte_in = hi_en ? bus_din[DW-1:BW] : bus_din[BW-1:0];
        ack     = (state == ST_DONE);
    end

    // State, wait counter, latched request and read assembly.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            phase     <= 1'b0;
            cnt       <= '0;
            lat_addr  <= '0;
            lat_we    <= 1'b0;
            lat_word  <= 1'b0;
            lat_io    <= 1'b0;
            lat_wdata <= '0;
            rdata     <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req) begin
                        lat_addr  <= req_addr;
                        lat_we    <= req_we;
                        lat_word  <= req_word;
                        lat_io    <= req_io;
                        lat_wdata <= req_wdata;
                        phase     <= 1'b0;
                        cnt       <= wait_cfg;
                        rdata     <= '0;
                        state     <= ST_BUS;
                    end
                end
                ST_BUS: begin
                    if (cnt != '0) begin
                        cnt <= cnt - {{(WS_W-1){1'b0}}, 1'b1};
                    end else if (ardy) begin
                        if (!lat_we) begin
                            if (!lat_word)  rdata <= {{BW{1'b0}}, byte_in};
                            else if (!split) rdata <= bus_din;
                            else if (!phase) rdata[BW-1:0] <= byte_in;
                            else             rdata[DW-1:BW] <= byte_in;
                        end
                        state <= (split && !phase) ? ST_GAP : ST_DONE;
                    end
                end
                ST_GAP: begin
                    phase <= 1'b1;
                    cnt   <= wait_cfg;
                    state <= ST_BUS;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R9: ack lasts one cycle.
    p_ack_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);
    // R8: a pending wait count keeps the strobe active.
    p_wait_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUS && cnt != '0) |=> (state == ST_BUS));
    // R8: a cycle never ends while ardy is low.
    p_ardy_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_BUS && !ardy) |=> (state == ST_BUS));
    // R5: the gap is followed by the second-half cycle.
    p_split_second_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |=> (state == ST_BUS && phase));
endmodule

// File: rtl/extbus_bridge.sv
// External bus bridge top: ties the sequencer, lane steering and
// peripheral select decode together and forms the pin strobes for the
// selected byte-enable convention.
// Assumes: mode_sel is a static strap; requests follow req/ack.
module extbus_bridge
    import extbus_pkg::*;
#(
    parameter int AW       = 23,
    parameter int DW       = 16,
    parameter int WS_W     = 4,
    parameter int PCS_N    = 7,
    parameter int WIN_BITS = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_sel,
    input  logic [WS_W-1:0]  wait_cfg,
    input  logic             req,
    input  logic             req_we,
    input  logic             req_word,
    input  logic             req_io,
    input  logic [AW-1:0]    req_addr,
    input  logic [DW-1:0]    req_wdata,
    output logic             ack,
    output logic [DW-1:0]    rdata,
    output logic [AW-1:0]    bus_addr,
    output logic [DW-1:0]    bus_dout,
    output logic             bus_oe,
    input  logic [DW-1:0]    bus_din,
    output logic             rd_n,
    output logic             wr_n,
    output logic             wrl_n,
    output logic             wrh_n,
    output logic             bhe_n,
    output logic [PCS_N-1:0] pcs_n,
    input  logic             ardy
);
    seq_state_t    state;
    logic          phase;
    logic [AW-1:0] lat_addr;
    logic          lat_we;
    logic          lat_word;
    logic          lat_io;
    logic [DW-1:0] lat_wdata;
    logic [AW-1:0] cyc_addr;
    logic          lo_en;
    logic          hi_en;
    logic          active;

    extbus_seq #(.AW(AW), .DW(DW), .WS_W(WS_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_we    (req_we),
        .req_word  (req_word),
        .req_io    (req_io),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .wait_cfg  (wait_cfg),
        .ardy      (ardy),
        .bus_din   (bus_din),
        .hi_en     (hi_en),
        .state     (state),
        .phase     (phase),
        .lat_addr  (lat_addr),
        .lat_we    (lat_we),
        .lat_word  (lat_word),
        .lat_io    (lat_io),
        .lat_wdata (lat_wdata),
        .ack       (ack),
        .rdata     (rdata)
    );

    extbus_lane_steer #(.AW(AW), .DW(DW)) u_steer (
        .mode_sel  (mode_sel),
        .base_addr (lat_addr),
        .word      (lat_word),
        .phase     (phase),
        .wdata     (lat_wdata),
        .cyc_addr  (cyc_addr),
        .pin_addr  (bus_addr),
        .lo_en     (lo_en),
        .hi_en     (hi_en),
        .dout      (bus_dout)
    );

    extbus_pcs_decode #(.AW(AW), .PCS_N(PCS_N), .WIN_BITS(WIN_BITS)) u_pcs (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (active & lat_io),
        .addr  (cyc_addr),
        .pcs_n (pcs_n)
    );

    // Strobes and lane enables for the chosen convention.
    always_comb begin
        active = (state == ST_BUS);
        rd_n   = ~(active & ~lat_we);
        wr_n   = ~(active & lat_we & ~mode_sel);
        wrl_n  = ~(active & lat_we & mode_sel & lo_en);
        wrh_n  = ~(active & lat_we & mode_sel & hi_en);
        bhe_n  = ~(active & ~mode_sel & hi_en);
        bus_oe = active & lat_we;
    end

    // R2: word addressing in mode 1 during a strobe.
    p_mode1_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel && (!rd_n || !wrl_n || !wrh_n)) |-> (bus_addr[0] == 1'b0));
    // R7: selects only during a strobe.
    p_pcs_in_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pcs_n != '1) |-> (!rd_n || !wr_n || !wrl_n || !wrh_n));
    // R10: mode 0 never uses the lane write strobes.
    p_mode0_lane_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_sel |-> (wrl_n && wrh_n));
endmodule

// File: tb/sim_extbus_bridge.sv
module sim_extbus_bridge;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_sel = 1'b0;
    logic [3:0]  wait_cfg = 4'd0;
    logic        req = 1'b0, req_we = 1'b0, req_word = 1'b0, req_io = 1'b0;
    logic [22:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic        ack;
    logic [15:0] rdata;
    logic [22:0] bus_addr;
    logic [15:0] bus_dout;
    logic        bus_oe;
    logic [15:0] bus_din = '0;
    logic        rd_n, wr_n, wrl_n, wrh_n, bhe_n;
    logic [6:0]  pcs_n;
    logic        ardy = 1'b1;

    int checks = 0;
    int errors = 0;

    // recorded cycle data
    int          n_cyc, gap_len;
    int          c_len [2];
    logic [22:0] c_addr [2];
    logic [15:0] c_dout [2];
    logic        c_bhe [2], c_wr [2], c_wrl [2], c_wrh [2], c_rd [2], c_oe [2];
    logic [6:0]  c_pcs [2];
    logic [15:0] got_rdata;

    always #2 clk = ~clk;

    extbus_bridge u0 (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .wait_cfg(wait_cfg),
        .req(req), .req_we(req_we), .req_word(req_word), .req_io(req_io),
        .req_addr(req_addr), .req_wdata(req_wdata), .ack(ack), .rdata(rdata),
        .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_oe(bus_oe),
        .bus_din(bus_din), .rd_n(rd_n), .wr_n(wr_n), .wrl_n(wrl_n),
        .wrh_n(wrh_n), .bhe_n(bhe_n), .pcs_n(pcs_n), .ardy(ardy)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Runs one access and records each strobe cycle.
    task automatic run_access(input logic io, input logic we, input logic word,
                              input logic [22:0] addr, input logic [15:0] wd,
                              input logic [15:0] din0, input logic [15:0] din1,
                              input int hold);
        bit prev_act = 0;
        int k = 0;
        int guard = 0;
        n_cyc = 0; gap_len = 0; got_rdata = '0;
        c_len[0] = 0; c_len[1] = 0;
        @(negedge clk);
        req = 1; req_io = io; req_we = we; req_word = word;
        req_addr = addr; req_wdata = wd;
        ardy = (hold == 0);
        while (guard < 500) begin
            bit act;
            guard++;
            @(negedge clk);
            act = !rd_n || !wr_n || !wrl_n || !wrh_n;
            if (ack) begin
                got_rdata = rdata;
                req = 0;
                ardy = 1;
                break;
            end
            if (act) begin
                if (!prev_act) begin
                    if (n_cyc < 2) begin
                        c_addr[n_cyc] = bus_addr; c_dout[n_cyc] = bus_dout;
                        c_bhe[n_cyc] = bhe_n; c_wr[n_cyc] = wr_n;
                        c_wrl[n_cyc] = wrl_n; c_wrh[n_cyc] = wrh_n;
                        c_rd[n_cyc] = rd_n; c_pcs[n_cyc] = pcs_n;
                        c_oe[n_cyc] = bus_oe;
                        bus_din = (n_cyc == 0) ? din0 : din1;
                    end
                    n_cyc++;
                    k = 0;
                end else begin
                    k++;
                end
                if (n_cyc <= 2) c_len[n_cyc-1] = k + 1;
                ardy = (k >= hold);
            end else if (n_cyc == 1) begin
                gap_len++;
            end
            prev_act = act;
        end
        @(negedge clk);
        chk("R9 ack single pulse", ack, 0);
    endtask

    task automatic t_reset;
        chk("R9 reset ack", ack, 0);
        chk("R9 reset strobes", {rd_n, wr_n, wrl_n, wrh_n, bhe_n}, 5'h1f);
        chk("R7 reset selects", pcs_n, 7'h7f);
    endtask

    task automatic t_m0_byte_even_write;
        mode_sel = 0; wait_cfg = 2;
        run_access(0, 1, 0, 23'h100, 16'h0023, 0, 0, 0);
        chk("R1 cycles", n_cyc, 1);
        chk("R1 addr", c_addr[0], 23'h100);
        chk("R1 bhe even byte", c_bhe[0], 1);
        chk("R3 dup byte", c_dout[0], 16'h2323);
        chk("R3 oe", c_oe[0], 1);
        chk("R10 wr_n", c_wr[0], 0);
        chk("R10 lane strobes idle", {c_wrl[0], c_wrh[0]}, 2'b11);
        chk("R8 len wait2", c_len[0], 3);
    endtask

    task automatic t_m0_byte_odd_read;
        mode_sel = 0; wait_cfg = 0;
        run_access(1, 0, 0, 23'hC01, 0, 16'h55AA, 0, 0);
        chk("R1 addr odd", c_addr[0], 23'hC01);
        chk("R1 bhe odd byte", c_bhe[0], 0);
        chk("R6 odd byte upper lane", got_rdata, 16'h0055);
        chk("R7 pcs6", c_pcs[0], 7'h3f);
        chk("R8 len wait0", c_len[0], 1);
    endtask

    task automatic t_m0_word_even_read;
        mode_sel = 0; wait_cfg = 1;
        run_access(1, 0, 1, 23'h400, 0, 16'h1234, 0, 0);
        chk("R1 word cycles", n_cyc, 1);
        chk("R1 bhe word", c_bhe[0], 0);
        chk("R6 word read", got_rdata, 16'h1234);
        chk("R7 pcs2", c_pcs[0], 7'h7b);
    endtask

    task automatic t_m0_byte_even_read;
        mode_sel = 0; wait_cfg = 0;
        run_access(0, 0, 0, 23'h40, 0, 16'h11EE, 0, 0);
        chk("R6 even byte lower lane", got_rdata, 16'h00EE);
        chk("R7 memory no select", c_pcs[0], 7'h7f);
    endtask

    task automatic t_m1_byte_odd_write;
        mode_sel = 1; wait_cfg = 0;
        run_access(1, 1, 0, 23'hC01, 16'h0023, 0, 0, 0);
        chk("R4 even word addr", c_addr[0], 23'hC00);
        chk("R4 only wrh", {c_wrl[0], c_wrh[0]}, 2'b10);
        chk("R2 wr_n idle", c_wr[0], 1);
        chk("R2 bhe idle", c_bhe[0], 1);
        chk("R3 dup byte m1", c_dout[0], 16'h2323);
    endtask

    task automatic t_m1_word_even_write;
        mode_sel = 1; wait_cfg = 0;
        run_access(0, 1, 1, 23'h200, 16'h1234, 0, 0, 0);
        chk("R2 cycles", n_cyc, 1);
        chk("R2 both lanes", {c_wrl[0], c_wrh[0]}, 2'b00);
        chk("R2 data", c_dout[0], 16'h1234);
    endtask

    task automatic t_m1_word_odd_write;
        mode_sel = 1; wait_cfg = 0;
        run_access(1, 1, 1, 23'hC01, 16'h5678, 0, 0, 0);
        chk("R5 two cycles", n_cyc, 2);
        chk("R5 first addr", c_addr[0], 23'hC00);
        chk("R5 first wrh", {c_wrl[0], c_wrh[0]}, 2'b10);
        chk("R5 first data", c_dout[0], 16'h7856);
        chk("R5 second addr", c_addr[1], 23'hC02);
        chk("R5 second wrl", {c_wrl[1], c_wrh[1]}, 2'b01);
        chk("R5 second data", c_dout[1], 16'h7856);
        chk("R5 gap", gap_len, 1);
        chk("R7 second pcs6", c_pcs[1], 7'h3f);
    endtask

    task automatic t_m0_word_odd_read;
        mode_sel = 0; wait_cfg = 1;
        run_access(0, 0, 1, 23'h601, 0, 16'hAB00, 16'h00CD, 0);
        chk("R5 read two cycles", n_cyc, 2);
        chk("R5 first addr m0", c_addr[0], 23'h601);
        chk("R5 first bhe", c_bhe[0], 0);
        chk("R5 second addr m0", c_addr[1], 23'h602);
        chk("R5 second bhe", c_bhe[1], 1);
        chk("R6 reassembled", got_rdata, 16'hCDAB);
        chk("R8 second len", c_len[1], 2);
    endtask

    task automatic t_ardy;
        mode_sel = 0; wait_cfg = 1;
        run_access(0, 0, 1, 23'h10, 0, 16'hBEEF, 0, 4);
        chk("R8 ardy extends", c_len[0], 5);
        wait_cfg = 5;
        run_access(0, 0, 1, 23'h10, 0, 16'hBEEF, 0, 2);
        chk("R8 wait dominates", c_len[0], 6);
        chk("R6 data after wait", got_rdata, 16'hBEEF);
    endtask

    task automatic t_pcs_edges;
        mode_sel = 0; wait_cfg = 0;
        run_access(1, 0, 0, 23'hE00, 0, 0, 0, 0);
        chk("R7 past last window", c_pcs[0], 7'h7f);
        run_access(1, 0, 0, 23'h1FF, 0, 0, 0, 0);
        chk("R7 pcs0 top", c_pcs[0], 7'h7e);
        run_access(0, 0, 0, 23'hC00, 0, 0, 0, 0);
        chk("R7 memory space", c_pcs[0], 7'h7f);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        t_reset();
        t_m0_byte_even_write();
        t_m0_byte_odd_read();
        t_m0_word_even_read();
        t_m0_byte_even_read();
        t_m1_byte_odd_write();
        t_m1_word_even_write();
        t_m1_word_odd_write();
        t_m0_word_odd_read();
        t_ardy();
        t_pcs_edges();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule